// File: doc/BRIEF.md
# Protected-Configuration Watchdog Timer

This block is a single-clock watchdog with an 8-bit control register. Software can write and read the register. The register holds three fields: an unlock flag, a run flag and a 3-bit period select. While the run flag is set, the block counts clock cycles. A kick strobe restarts the count. When the count reaches the selected period, the block raises a one-cycle reset pulse and starts counting again from zero.

Turning the watchdog off and changing its period are both protected. A write must first set the unlock flag and the run flag together. That write opens a window that lasts four clock cycles. Inside the window, a following write may clear the run flag or load a new period select. When the window closes, the unlock flag drops by itself. A two-bit safety-level input can pin the watchdog on: at level 2, no write can clear the run flag.

The base period is a parameter, `BASE_CYCLES`, with a default of 16384. Each step of the select doubles the period. A simulation can therefore use a small base and still cover all eight periods.

Top module: `wdg_protected`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0x00 and `wdt_rst` is low.
- R2: Register fields are: bit 4 is the unlock flag, bit 3 is the run flag, and bits 2..0 are the period select. Bits 7..5 always read 0, and writing them has no effect.
- R3: A write with bit 3 = 1 sets the run flag at any time, with no unlock needed.
- R4: A write with bit 3 = 0 leaves the run flag set when the unlock flag is 0.
- R5: A write with bits 4 and 3 both 1 opens an unlock window. A write that clears bit 3 on any of the next four clock edges turns the watchdog off. The same write on the fifth edge or later is refused.
- R6: The unlock flag reads 1 for the four cycles after an opening write, then reads 0 with no further write.
- R7: Writes to bits 2..0 take effect only while the unlock flag is 1. At other times the select keeps its value.
- R8: The period is `BASE_CYCLES << select`. A pulse on `wdt_rst` follows exactly that many clock edges after the count was last cleared. The count is cleared by enabling, by a kick, by a change of select, or by the previous pulse. A change of select clears the count one edge after the write.
- R9: Each `wdt_rst` pulse lasts one cycle. Counting then restarts, so the pulses repeat with the selected period.
- R10: A `kick` sampled high clears the count. Kicks spaced closer than the period prevent any pulse.
- R11: While the run flag is 0, `wdt_rst` stays low however long the wait.
- R12: While `safety_level` is 2, the run flag cannot be cleared, even by a correct unlock sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| safety_level | input | 2 | Safety level; 2 locks the watchdog on |
| kick | input | 1 | Counter restart strobe |
| wdt_rst | output | 1 | One-cycle timeout reset pulse |

## Verification
The unlock window depends on a hidden countdown, so a wrong window length shows up right away in two ways. A disable attempt on the fourth or fifth edge after the opening write is accepted or refused wrongly. The unlock bit read back on those same edges is also wrong. A wrong timeout count shows up only at the next expected pulse, which arrives early or late by a measurable number of cycles. Sweeping every select value with a small base makes any error in the doubling visible within at most a few hundred cycles.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CTRL_W     = 8;
    localparam int SEL_W      = 3;
    localparam int WIN_CYCLES = 4;
    localparam logic [1:0] SAFETY_LOCKED = 2'd2;

    typedef struct packed {
        logic [2:0]       rsvd;
        logic             unlock;
        logic             run;
        logic [SEL_W-1:0] sel;
    } ctrl_word_t;

    function automatic ctrl_word_t pack_ctrl(logic unlock, logic run, logic [SEL_W-1:0] sel);
        ctrl_word_t w;
        w.rsvd   = '0;
        w.unlock = unlock;
        w.run    = run;
        w.sel    = sel;
        return w;
    endfunction

    function automatic int unsigned period_last(int unsigned base, logic [SEL_W-1:0] sel);
        return (base << sel) - 1;
    endfunction

    function automatic logic is_arming(ctrl_word_t w);
        return w.unlock && w.run;
    endfunction

endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  ctrl_word_t       wr_data,
    input  logic [1:0]       safety_level,
    output logic             unlock_o,
    output logic             run_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             sel_chg_o
);
    localparam int WCW = $clog2(WIN_CYCLES + 1);

    logic           unlock_q;
    logic           run_q;
    logic [SEL_W-1:0] sel_q;
    logic           sel_chg_q;
    logic [WCW-1:0] win_q;
    logic           locked;

    assign locked = (safety_level == SAFETY_LOCKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_q  <= 1'b0;
            run_q     <= 1'b0;
            sel_q     <= '0;
            sel_chg_q <= 1'b0;
            win_q     <= '0;
        end else begin
            sel_chg_q <= 1'b0;
            if (unlock_q) begin
                if (win_q == WCW'(1)) unlock_q <= 1'b0;
                win_q <= win_q - WCW'(1);
            end
            if (wr_en) begin
                if (unlock_q) begin
                    if (wr_data.sel != sel_q) begin
                        sel_q     <= wr_data.sel;
                        sel_chg_q <= 1'b1;
                    end
                    if (wr_data.run)  run_q <= 1'b1;
                    else if (!locked) run_q <= 1'b0;
                end else if (wr_data.run) begin
                    run_q <= 1'b1;
                end
                if (is_arming(wr_data)) begin
                    unlock_q <= 1'b1;
                    win_q    <= WCW'(WIN_CYCLES);
                end
            end
        end
    end

    assign unlock_o  = unlock_q;
    assign run_o     = run_q;
    assign sel_o     = sel_q;
    assign sel_chg_o = sel_chg_q;

    AST_RUN_CLEAR_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        (run_q && !unlock_q) |=> run_q);                                     // R4
    AST_LOCKED_STAYS_ON: assert property (@(posedge clk) disable iff (rst)
        (run_q && locked) |=> run_q);                                        // R12
    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !unlock_q |=> $stable(sel_q));                                       // R7
    AST_UNLOCK_BY_ARM: assert property (@(posedge clk) disable iff (rst)
        $rose(unlock_q) |-> $past(wr_en && wr_data.unlock && wr_data.run)); // R5

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int unsigned BASE_CYCLES = 16384
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             kick,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int CW = $clog2(BASE_CYCLES * (2 ** ((2 ** SEL_W) - 1))) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          expire_q;

    assign last = CW'(period_last(BASE_CYCLES, sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (!run || kick || restart) begin
                cnt_q <= '0;
            end else if (cnt_q == last) begin
                cnt_q    <= '0;
                expire_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign expire = expire_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        expire_q |=> !expire_q);                                             // R9
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !run |=> !expire_q);                                                 // R11
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt_q == '0) && !expire_q);                                // R10

endmodule

// File: rtl/wdg_protected.sv
module wdg_protected
    import wdg_pkg::*;
#(
    parameter int unsigned BASE_CYCLES = 16384
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic [1:0]  safety_level,
    input  logic        kick,
    output logic        wdt_rst
);
    logic             unlock;
    logic             run;
    logic [SEL_W-1:0] sel;
    logic             sel_chg;
    ctrl_word_t       wr_word;

    assign wr_word = ctrl_word_t'(wr_data);

    wdg_ctrl_reg u_reg (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_word),
        .safety_level (safety_level),
        .unlock_o     (unlock),
        .run_o        (run),
        .sel_o        (sel),
        .sel_chg_o    (sel_chg)
    );

    wdg_counter #(.BASE_CYCLES(BASE_CYCLES)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .kick    (kick),
        .restart (sel_chg),
        .sel     (sel),
        .expire  (wdt_rst)
    );

    assign rd_data = pack_ctrl(unlock, run, sel);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:5] == 3'b000);                                             // R2

endmodule

// File: tb/wdg_protected_tb.sv
module wdg_protected_tb_top;
    localparam int unsigned BASE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] safety_level = 2'd0;
    logic       kick = 1'b0;
    logic       wdt_rst;

    int errors = 0;
    int checks = 0;
    logic [2:0] cur_sel = 3'd0;

    always #10 clk = ~clk;

    wdg_protected #(.BASE_CYCLES(BASE)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .safety_level(safety_level), .kick(kick), .wdt_rst(wdt_rst)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // bits: [4]=unlock [3]=run [2:0]=select
    function automatic logic [7:0] word(logic u, logic r, logic [2:0] s);
        return {3'b000, u, r, s};
    endfunction

    task automatic disable_wd();
        wr(word(1, 1, cur_sel));
        wr(word(0, 0, cur_sel));
    endtask

    task automatic wait_pulse(int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!wdt_rst && n < limit);
        if (!wdt_rst) n = -1;
    endtask

    initial begin
        idle(3);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        chk("R1 rd_data", rd_data, 0);
        chk("R1 wdt_rst", wdt_rst, 0);

        // R2/R3: enable with reserved bits set, no unlock
        wr(8'hE8);
        chk("R3 enable without unlock / R2 reserved read 0", rd_data, 8'h08);
        // R4: clear without unlock refused
        wr(8'h00);
        chk("R4 clear refused", rd_data, 8'h08);
        // R7: select write ignored while locked
        wr(8'h0D);
        chk("R7 select ignored", rd_data, 8'h08);

        // R6: unlock flag lifetime
        wr(word(1, 1, 0));
        for (int k = 0; k < 6; k++) begin
            chk($sformatf("R6 unlock flag k=%0d", k), rd_data[4], (k < 4) ? 1 : 0);
            @(negedge clk);
        end

        // R5: window boundary sweep
        for (int d = 0; d <= 5; d++) begin
            wr(word(0, 1, cur_sel));
            idle(6);
            wr(word(1, 1, cur_sel));
            idle(d);
            wr(word(0, 0, cur_sel));
            chk($sformatf("R5 disable after %0d idle", d), rd_data[3], (d < 4) ? 0 : 1);
            idle(6);
        end
        wr(word(0, 1, cur_sel));
        idle(6);
        disable_wd();
        chk("R5 disabled", rd_data[3], 0);

        // R8/R9: sweep every select
        for (int i = 1; i <= 8; i++) begin
            logic [2:0] s;
            int n;
            int per;
            s = 3'(i % 8);
            per = BASE << s;
            idle(6);
            wr(word(1, 1, cur_sel));
            wr(word(0, 1, s));
            cur_sel = s;
            chk($sformatf("R7 select %0d loaded", s), rd_data, word(1, 1, s));
            wait_pulse(per + 10, n);
            chk($sformatf("R8 period sel=%0d", s), n, per + 1);
            @(negedge clk);
            chk($sformatf("R9 one-cycle sel=%0d", s), wdt_rst, 0);
            wait_pulse(per + 10, n);
            chk($sformatf("R9 repeat sel=%0d", s), n, per - 1);
            disable_wd();
        end

        // R11: disabled stays quiet
        begin
            int seen = 0;
            for (int k = 0; k < 700; k++) begin
                @(negedge clk);
                if (wdt_rst) seen++;
            end
            chk("R11 no pulse while off", seen, 0);
        end

        // R10: kicks (select 0, period BASE)
        begin
            int seen = 0;
            int n;
            wr(word(0, 1, cur_sel));
            for (int k = 0; k < 20; k++) begin
                kick = 1'b1;
                @(negedge clk);
                if (wdt_rst) seen++;
                kick = 1'b0;
                @(negedge clk);
                if (wdt_rst) seen++;
            end
            chk("R10 kicks hold off pulse", seen, 0);
            kick = 1'b1;
            @(negedge clk);
            kick = 1'b0;
            wait_pulse(BASE + 10, n);
            chk("R10 pulse after last kick", n, BASE);
        end

        // R12: safety lock
        safety_level = 2'd2;
        idle(6);
        disable_wd();
        chk("R12 locked stays on", rd_data[3], 1);
        begin
            int n;
            wait_pulse(BASE + 10, n);
            chk("R12 still expires", (n > 0) ? 1 : 0, 1);
        end
        safety_level = 2'd0;
        idle(6);
        disable_wd();
        chk("R12 unlocked level clears", rd_data[3], 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule